// File: doc/BRIEF.md
# Registered bidirectional bus transceiver

This block connects two bidirectional data ports, A and B, split into independent 8-bit lanes. Each lane has a register for the A-to-B direction and a register for the B-to-A direction. A per-lane isolation input and a direction input decide which port the lane drives, if any. A per-direction select input decides whether the driven port carries the live word from the opposite port or the word held in that direction's register. This lets stored data be replayed onto a bus while the registers keep taking new samples.

The capture controls are level inputs sampled by the core clock. A register loads on the first clock edge at which its capture input is seen high after being low. Loading happens whatever the isolation, direction and select inputs are doing. The pads are presented as split signals: an input word, an output word and one output-enable per lane for each port, so the tri-state cell sits outside the block. A register whose own port is being driven by the lane loads the word the lane drives, not the pad input.

Top module: `rbx_xcvr`

## Requirements
- R1: Synchronous active-low reset clears both registers of every lane to zero.
- R2: The A-to-B register of a lane loads that lane's A word at the first clock edge where its capture input is high after a low sample. Further edges with the input still high do not reload it.
- R3: The B-to-A register of a lane loads that lane's B word under the same rule, using its own capture input.
- R4: Loading does not depend on the isolation, direction or select inputs. Both registers load with isolation active, on the same edge or on separate edges.
- R5: With the lane's isolation input high, both of its enables are 0 and both of its output words are 0. An output word is also 0 whenever its enable is 0.
- R6: With isolation low and direction 0, the A enable is 1. The A word equals the live B word when the B-to-A select is 0, and the B-to-A register when that select is 1. Both follow in the same cycle.
- R7: With isolation low and direction 1, the B enable is 1. The B word equals the live A word when the A-to-B select is 0, and the A-to-B register when that select is 1. Both follow in the same cycle.
- R8: A lane never has both of its enables high at once.
- R9: On every cycle the driven word is exactly the selected source, live or stored, as a whole word. No bit-mix of the two appears, even when the select toggles every cycle.
- R10: When a register loads from a port that its own lane is driving, it takes the lane's driven word and ignores that port's input word.
- R11: Lanes are independent. Lane k occupies bits [8k+7:8k] of each data word and bit k of each control and enable vector. Controls of one lane never change the other lane's outputs or registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| out_off | input | LANES | Per-lane isolation, 1 = neither port driven |
| to_b | input | LANES | Per-lane direction, 1 = drive B, 0 = drive A |
| strobe_ab | input | LANES | Per-lane A-to-B capture input, loads on rising level |
| strobe_ba | input | LANES | Per-lane B-to-A capture input, loads on rising level |
| use_reg_ab | input | LANES | 1 = B carries the A-to-B register, 0 = live A |
| use_reg_ba | input | LANES | 1 = A carries the B-to-A register, 0 = live B |
| a_in | input | LANES*LANE_W | Word seen at the A pads |
| a_out | output | LANES*LANE_W | Word to drive on the A pads |
| a_en | output | LANES | Per-lane A pad output enable |
| b_in | input | LANES*LANE_W | Word seen at the B pads |
| b_out | output | LANES*LANE_W | Word to drive on the B pads |
| b_en | output | LANES | Per-lane B pad output enable |

## Verification
Enables and output words are combinational from the controls, the input words and the registers. The bench therefore changes inputs on the falling edge and compares these outputs within the same low phase. A register load takes effect at the first rising edge that sees its capture input high. The bench raises the capture input on a falling edge, lets one rising edge pass, and then reads the register back through a stored transfer on the next low phase. Expected register contents come from a bench model that applies the loading rules, including the rule that a lane driving a port loads its own driven word. A mid-run reset is checked by readback after two clock edges with reset low.

// File: rtl/rbx_pkg.sv
package rbx_pkg;

    typedef enum logic [1:0] {
        DRV_NONE = 2'd0,
        DRV_A    = 2'd1,
        DRV_B    = 2'd2
    } drive_e;

    // Isolation dominates; otherwise direction picks the single driven side.
    function automatic drive_e pick_drive(input logic off, input logic toward_b);
        if (off) begin
            return DRV_NONE;
        end
        return toward_b ? DRV_B : DRV_A;
    endfunction

endpackage

// File: rtl/rbx_edge.sv
module rbx_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o
);

    typedef struct packed {
        logic [N-1:0] seen;
    } edge_t;

    edge_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.seen = lvl_i;
        rise_o    = lvl_i & ~st_q.seen;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // A level held high yields one load strobe only (R2, R3).
    for (genvar i = 0; i < N; i++) begin : g_chk
        p_single_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
            rise_o[i] |=> !rise_o[i]);
    end

endmodule

// File: rtl/rbx_store.sv
module rbx_store #(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_ab,
    input  logic              take_ba,
    input  logic [LANE_W-1:0] src_ab,
    input  logic [LANE_W-1:0] src_ba,
    output logic [LANE_W-1:0] ab_q,
    output logic [LANE_W-1:0] ba_q
);

    typedef struct packed {
        logic [LANE_W-1:0] ab;
        logic [LANE_W-1:0] ba;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take_ab) begin
            st_d.ab = src_ab;
        end
        if (take_ba) begin
            st_d.ba = src_ba;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ab_q = st_q.ab;
    assign ba_q = st_q.ba;

    p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ab_q == '0 && ba_q == '0));

    p_load_ab_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take_ab |=> ab_q == $past(src_ab));

    p_keep_ab_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !take_ab |=> $stable(ab_q));

    p_load_ba_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_ba |=> ba_q == $past(src_ba));

    p_keep_ba_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !take_ba |=> $stable(ba_q));

endmodule

// File: rtl/rbx_steer.sv
module rbx_steer
    import rbx_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              out_off,
    input  logic              to_b,
    input  logic              use_reg_ab,
    input  logic              use_reg_ba,
    input  logic [LANE_W-1:0] a_in,
    input  logic [LANE_W-1:0] b_in,
    input  logic [LANE_W-1:0] ab_q,
    input  logic [LANE_W-1:0] ba_q,
    output logic [LANE_W-1:0] a_out,
    output logic [LANE_W-1:0] b_out,
    output logic              a_en,
    output logic              b_en,
    output logic [LANE_W-1:0] src_ab,
    output logic [LANE_W-1:0] src_ba
);

    drive_e mode;

    always_comb begin
        mode  = pick_drive(out_off, to_b);
        a_en  = (mode == DRV_A);
        b_en  = (mode == DRV_B);
        a_out = '0;
        b_out = '0;
        unique case (mode)
            DRV_A:   a_out = use_reg_ba ? ba_q : b_in;
            DRV_B:   b_out = use_reg_ab ? ab_q : a_in;
            default: ;
        endcase
        // A driven side loads the word the lane itself places on it.
        src_ab = a_en ? a_out : a_in;
        src_ba = b_en ? b_out : b_in;
    end

    p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_off |-> (!a_en && !b_en && a_out == '0 && b_out == '0));

    p_one_side_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_en && b_en));

    p_whole_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
        a_en |-> (a_out == b_in || a_out == ba_q));

    p_whole_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
        b_en |-> (b_out == a_in || b_out == ab_q));

endmodule

// File: rtl/rbx_xcvr.sv
module rbx_xcvr
    import rbx_pkg::*;
#(
    parameter  int LANE_W = 8,
    parameter  int LANES  = 2,
    localparam int BUS_W  = LANE_W * LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] out_off,
    input  logic [LANES-1:0] to_b,
    input  logic [LANES-1:0] strobe_ab,
    input  logic [LANES-1:0] strobe_ba,
    input  logic [LANES-1:0] use_reg_ab,
    input  logic [LANES-1:0] use_reg_ba,
    input  logic [BUS_W-1:0] a_in,
    output logic [BUS_W-1:0] a_out,
    output logic [LANES-1:0] a_en,
    input  logic [BUS_W-1:0] b_in,
    output logic [BUS_W-1:0] b_out,
    output logic [LANES-1:0] b_en
);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [1:0]        take;
        logic [LANE_W-1:0] ab_q;
        logic [LANE_W-1:0] ba_q;
        logic [LANE_W-1:0] src_ab;
        logic [LANE_W-1:0] src_ba;

        rbx_edge #(.N(2)) u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl_i  ({strobe_ba[k], strobe_ab[k]}),
            .rise_o (take)
        );

        rbx_store #(.LANE_W(LANE_W)) u_store (
            .clk     (clk),
            .rst_n   (rst_n),
            .take_ab (take[0]),
            .take_ba (take[1]),
            .src_ab  (src_ab),
            .src_ba  (src_ba),
            .ab_q    (ab_q),
            .ba_q    (ba_q)
        );

        rbx_steer #(.LANE_W(LANE_W)) u_steer (
            .clk        (clk),
            .rst_n      (rst_n),
            .out_off    (out_off[k]),
            .to_b       (to_b[k]),
            .use_reg_ab (use_reg_ab[k]),
            .use_reg_ba (use_reg_ba[k]),
            .a_in       (a_in[k*LANE_W +: LANE_W]),
            .b_in       (b_in[k*LANE_W +: LANE_W]),
            .ab_q       (ab_q),
            .ba_q       (ba_q),
            .a_out      (a_out[k*LANE_W +: LANE_W]),
            .b_out      (b_out[k*LANE_W +: LANE_W]),
            .a_en       (a_en[k]),
            .b_en       (b_en[k]),
            .src_ab     (src_ab),
            .src_ba     (src_ba)
        );

        // With isolation active, a load takes the pad input word (R4).
        p_iso_load_ab_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (take[0] && out_off[k]) |=> ab_q == $past(a_in[k*LANE_W +: LANE_W]));

        p_iso_load_ba_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (take[1] && out_off[k]) |=> ba_q == $past(b_in[k*LANE_W +: LANE_W]));
    end

endmodule

// File: tb/rbx_xcvr_tb_top.sv
`timescale 1ns/1ps
module rbx_xcvr_tb_top;

    localparam int S  = 2;
    localparam int W  = 8;
    localparam int BW = S * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [S-1:0]  out_off, to_b, strobe_ab, strobe_ba, use_reg_ab, use_reg_ba;
    logic [BW-1:0] a_in, b_in, a_out, b_out;
    logic [S-1:0]  a_en, b_en;

    logic [W-1:0]  m_ab [S];
    logic [W-1:0]  m_ba [S];
    int            n_chk = 0;
    int            n_bad = 0;
    bit            done = 1'b0;

    always #2.5 clk = ~clk;

    rbx_xcvr #(.LANE_W(W), .LANES(S)) dut_i (
        .clk, .rst_n, .out_off, .to_b, .strobe_ab, .strobe_ba,
        .use_reg_ab, .use_reg_ba, .a_in, .a_out, .a_en, .b_in, .b_out, .b_en
    );

    task automatic chk(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [BW-1:0] exp_a();
        logic [BW-1:0] r = '0;
        for (int k = 0; k < S; k++)
            if (!out_off[k] && !to_b[k])
                r[k*W +: W] = use_reg_ba[k] ? m_ba[k] : b_in[k*W +: W];
        return r;
    endfunction

    function automatic logic [BW-1:0] exp_b();
        logic [BW-1:0] r = '0;
        for (int k = 0; k < S; k++)
            if (!out_off[k] && to_b[k])
                r[k*W +: W] = use_reg_ab[k] ? m_ab[k] : a_in[k*W +: W];
        return r;
    endfunction

    // Raise capture inputs on a falling edge, update model at the rising edge.
    task automatic fire(input logic [S-1:0] ab, input logic [S-1:0] ba);
        logic [BW-1:0] ea, eb;
        logic [W-1:0]  nab [S];
        logic [W-1:0]  nba [S];
        strobe_ab = ab;
        strobe_ba = ba;
        ea = exp_a();
        eb = exp_b();
        for (int k = 0; k < S; k++) begin
            nab[k] = (!out_off[k] && !to_b[k]) ? ea[k*W +: W] : a_in[k*W +: W];
            nba[k] = (!out_off[k] &&  to_b[k]) ? eb[k*W +: W] : b_in[k*W +: W];
        end
        @(posedge clk);
        for (int k = 0; k < S; k++) begin
            if (ab[k]) m_ab[k] = nab[k];
            if (ba[k]) m_ba[k] = nba[k];
        end
        @(negedge clk);
        strobe_ab = '0;
        strobe_ba = '0;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Read both registers of every lane back through stored transfers.
    task automatic readback(input string tag);
        logic [BW-1:0] xab, xba;
        for (int k = 0; k < S; k++) begin
            xab[k*W +: W] = m_ab[k];
            xba[k*W +: W] = m_ba[k];
        end
        out_off = '0; to_b = '1; use_reg_ab = '1;
        #0.5 chk({tag, " A-to-B register"}, b_out, xab);
        to_b = '0; use_reg_ba = '1;
        #0.5 chk({tag, " B-to-A register"}, a_out, xba);
        @(negedge clk);
    endtask

    initial begin
        out_off = '1; to_b = '0; strobe_ab = '0; strobe_ba = '0;
        use_reg_ab = '0; use_reg_ba = '0; a_in = '0; b_in = '0;
        for (int k = 0; k < S; k++) begin m_ab[k] = '0; m_ba[k] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R5 isolation
        #1 chk("R5 enables off", {a_en, b_en}, '0);
        chk("R5 words zero", a_out | b_out, '0);
        @(negedge clk);
        readback("R1 after reset");

        // R4 + R2: load A-to-B in isolation with odd direction/select settings
        out_off = '1; to_b = 2'b10; use_reg_ab = 2'b01; use_reg_ba = 2'b10;
        a_in = 16'h5A3C; b_in = 16'h0FF0;
        fire(2'b11, 2'b00);
        readback("R2 R4 load A");

        // R3 + R11: B-to-A load on lane 1 only
        out_off = '1; b_in = 16'hC381; a_in = 16'hEEEE;
        fire(2'b00, 2'b10);
        readback("R3 R11 lane1 B load");

        // R4: both registers on the same edge in isolation
        out_off = '1; a_in = 16'h1729; b_in = 16'h6E4B;
        fire(2'b11, 2'b11);
        readback("R4 both same edge");

        // R2: hold capture high, change A, no reload
        out_off = '1; a_in = 16'hA1B2;
        strobe_ab = 2'b01;
        @(posedge clk); m_ab[0] = 8'hB2;
        @(negedge clk); a_in = 16'h3344;
        @(posedge clk);
        @(negedge clk); strobe_ab = '0;
        @(posedge clk); @(negedge clk);
        readback("R2 held strobe");

        // R5 R6 R7 R8 R11: sweep all control combinations on both lanes
        for (int i = 0; i < 16; i++) begin
            for (int p = 0; p < 4; p++) begin
                logic [3:0] c0, c1;
                c0 = i[3:0]; c1 = 4'(15 - i);
                out_off    = {c1[0], c0[0]};
                to_b       = {c1[1], c0[1]};
                use_reg_ab = {c1[2], c0[2]};
                use_reg_ba = {c1[3], c0[3]};
                a_in = 16'(16'h1357 * (p + 1) + i);
                b_in = 16'(16'hF0E1 ^ (16'h0B0D * (p + 3)) ^ i);
                #1;
                chk("R6 R7 a_en", {14'b0, a_en}, {14'b0, ~out_off & ~to_b});
                chk("R6 R7 b_en", {14'b0, b_en}, {14'b0, ~out_off & to_b});
                chk("R6 R5 a_out", a_out, exp_a());
                chk("R7 R5 b_out", b_out, exp_b());
                chk("R8 both enables", {14'b0, a_en & b_en}, '0);
                @(negedge clk);
            end
        end

        // R9: toggle select every cycle, word must be the chosen source whole
        out_off = '0; to_b = '1; a_in = 16'hC35A;
        for (int c = 0; c < 8; c++) begin
            use_reg_ab = c[0] ? 2'b11 : 2'b00;
            #1 chk("R9 select toggle", b_out, exp_b());
            @(negedge clk);
        end

        // R10: lane 0 drives A with live B; A-to-B load takes driven word, not pad
        out_off = 2'b10; to_b = 2'b00; use_reg_ba = 2'b00;
        b_in = 16'h9934; a_in = 16'hFFC7;
        fire(2'b01, 2'b00);
        chk("R10 drive-side load", {8'h00, m_ab[0]}, 16'h0034);
        readback("R10 readback A");
        // lane 1 drives B from its register; B-to-A load takes that word
        out_off = 2'b01; to_b = 2'b10; use_reg_ab = 2'b10; b_in = 16'h5555;
        fire(2'b00, 2'b10);
        readback("R10 readback B");

        // R1: mid-run reset
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        for (int k = 0; k < S; k++) begin m_ab[k] = '0; m_ba[k] = '0; end
        readback("R1 mid-run reset");
        chk("R1 cleared lane0 ab", {8'h00, m_ab[0]}, 16'h0000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule